// File: doc/BRIEF.md
# OUT Endpoint DMA Request Sequencer

This block decides when a DMA engine should pull words out of an OUT endpoint's receive FIFO. When the packet receiver signals that a packet is waiting, the sequencer loads the received byte count and raises a request line. It lowers the line once the packet has been drained. Each word read the DMA performs while the request is high takes four bytes off a remaining-byte counter.

Ordinary packets are drained to the end, and a short tail of one to three bytes costs one final read. The last packet of a transfer is handled differently, and a mode input picks how. In one mode, DMA serves the packet until fewer than four bytes are left and then passes the remainder to firmware. In the other mode, the packet is passed to firmware whole, with no DMA request at all.

The hand-off is signalled by a sticky interrupt flag that firmware clears. While the flag is set, no new packet is taken up.

Top module: `oep_dma_seq`

## Requirements
- R1: After reset, dma_req_o, irq_o and pkt_done_o are 0 and remain_o is 0.
- R2: While dma_en_i is 0, dma_req_o stays 0 and a waiting packet is not taken up (remain_o is not reloaded).
- R3: When a packet is taken up (sequencer idle, pkt_rdy_i high, dma_en_i high, irq_o low), remain_o takes the 10-bit pkt_cnt_i on the next clock edge.
- R4: Each clock edge at which word_rd_i and dma_req_o are both high lowers remain_o by 4, or to 0 if it held fewer than 4.
- R5: For a packet with pkt_last_i = 0, dma_req_o is high while remain_o is non-zero, so a trailing 1 to 3 bytes take exactly one read. When remain_o reaches 0, pkt_done_o pulses high for exactly one cycle. A zero-byte packet gives a pulse with no request.
- R6: For a last packet with dma_mode_i = 0, dma_req_o is high only while remain_o >= 4. It is low in the cycle after the read that leaves fewer than 4 bytes. irq_o then sets, and remain_o keeps the leftover count (pkt_cnt_i mod 4).
- R7: For a last packet with dma_mode_i = 1, no request is raised, irq_o sets, and remain_o holds the whole byte count.
- R8: irq_o stays high until a cycle with irq_clr_i high. While irq_o is high, no new packet is taken up and dma_req_o does not rise.
- R9: After a packet is finished (done pulse or interrupt hand-off), no new packet is taken up until pkt_rdy_i has been low for at least one cycle.
- R10: dma_mode_i has no effect on packets with pkt_last_i = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dma_en_i | input | 1 | OUT DMA enable |
| dma_mode_i | input | 1 | Last-packet mode: 0 serve until under 4 bytes remain, 1 no DMA on last packet |
| pkt_rdy_i | input | 1 | A received packet waits in the FIFO |
| pkt_cnt_i | input | 10 | Byte count of the waiting packet |
| pkt_last_i | input | 1 | Waiting packet is the last of the transfer |
| word_rd_i | input | 1 | DMA performed one 32-bit FIFO read this cycle |
| irq_clr_i | input | 1 | Firmware clears the hand-off interrupt |
| dma_req_o | output | 1 | DMA request |
| irq_o | output | 1 | Sticky hand-off interrupt to firmware |
| pkt_done_o | output | 1 | One-cycle pulse: packet fully drained, packet-ready may be released |
| remain_o | output | 10 | Bytes of the current packet not yet read by DMA |

## Verification
The bench aims at the byte counts around the word size. These are zero, one to three, exact multiples of four, and the 1023-byte maximum, and each is tried as an ordinary and as a last packet in both modes. A sequencer that compares against the wrong threshold would show up as one read too many or too few, or as a wrong leftover count. A sequencer that keeps requesting after the tail would decrement remain_o to zero. The bench also holds a new packet against a set interrupt, against a disabled DMA and against a packet-ready that never drops. A design that ignored any of these would raise a request or reload remain_o when it should not.

// File: rtl/oep_dma_pkg.sv
package oep_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SERVE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/oep_dma_remain.sv
module oep_dma_remain #(
  parameter int CNT_W      = 10,
  parameter int WORD_BYTES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] remain_o,
  output logic             below_word_o,
  output logic             empty_o
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(WORD_BYTES);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q <= '0;
    end else if (load_i) begin
      remain_q <= cnt_i;
    end else if (dec_i) begin
      remain_q <= (remain_q >= STEP) ? remain_q - STEP : '0;
    end
  end

  assign remain_o     = remain_q;
  assign below_word_o = (remain_q < STEP);
  assign empty_o      = (remain_q == '0);
endmodule

// File: rtl/oep_dma_flag.sv
module oep_dma_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set has priority over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/oep_dma_ctrl.sv
module oep_dma_ctrl
  import oep_dma_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dma_en_i,
  input  logic mode_i,
  input  logic pkt_rdy_i,
  input  logic pkt_last_i,
  input  logic irq_busy_i,
  input  logic below_word_i,
  input  logic empty_i,
  output logic load_o,
  output logic serve_req_o,
  output logic set_irq_o,
  output logic done_o
);
  seq_state_e state_q, state_d;
  logic       last_q, last_d;
  logic       start;

  assign start = (state_q == ST_IDLE) && pkt_rdy_i && dma_en_i && !irq_busy_i;

  always_comb begin
    state_d     = state_q;
    last_d      = last_q;
    load_o      = 1'b0;
    serve_req_o = 1'b0;
    set_irq_o   = 1'b0;
    done_o      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load_o = 1'b1;
          last_d = pkt_last_i;
          if (pkt_last_i && mode_i) begin
            set_irq_o = 1'b1;       // whole last packet goes to firmware
            state_d   = ST_WAIT;
          end else begin
            state_d = ST_SERVE;
          end
        end
      end
      ST_SERVE: begin
        if (last_q) begin
          serve_req_o = !below_word_i;
          if (below_word_i) begin
            set_irq_o = 1'b1;
            state_d   = ST_WAIT;
          end
        end else begin
          serve_req_o = !empty_i;
          if (empty_i) begin
            done_o  = 1'b1;
            state_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (!pkt_rdy_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      last_q  <= last_d;
    end
  end
endmodule

// File: rtl/oep_dma_seq.sv
module oep_dma_seq #(
  parameter int CNT_W      = 10,
  parameter int WORD_BYTES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dma_en_i,
  input  logic             dma_mode_i,
  input  logic             pkt_rdy_i,
  input  logic [CNT_W-1:0] pkt_cnt_i,
  input  logic             pkt_last_i,
  input  logic             word_rd_i,
  input  logic             irq_clr_i,
  output logic             dma_req_o,
  output logic             irq_o,
  output logic             pkt_done_o,
  output logic [CNT_W-1:0] remain_o
);
  logic load, serve_req, set_irq, below_word, empty, dec;

  assign dma_req_o = serve_req && dma_en_i;
  assign dec       = word_rd_i && dma_req_o;

  oep_dma_remain #(
    .CNT_W      (CNT_W),
    .WORD_BYTES (WORD_BYTES)
  ) u_remain (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .cnt_i        (pkt_cnt_i),
    .dec_i        (dec),
    .remain_o     (remain_o),
    .below_word_o (below_word),
    .empty_o      (empty)
  );

  oep_dma_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dma_en_i     (dma_en_i),
    .mode_i       (dma_mode_i),
    .pkt_rdy_i    (pkt_rdy_i),
    .pkt_last_i   (pkt_last_i),
    .irq_busy_i   (irq_o),
    .below_word_i (below_word),
    .empty_i      (empty),
    .load_o       (load),
    .serve_req_o  (serve_req),
    .set_irq_o    (set_irq),
    .done_o       (pkt_done_o)
  );

  oep_dma_flag u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_irq),
    .clr_i  (irq_clr_i),
    .flag_o (irq_o)
  );
endmodule

// File: rtl/oep_dma_seq_chk.sv
module oep_dma_seq_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dma_en_i,
  input logic             word_rd_i,
  input logic             irq_clr_i,
  input logic             dma_req_o,
  input logic             irq_o,
  input logic             pkt_done_o,
  input logic [CNT_W-1:0] remain_o
);
  assert_no_req_when_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_en_i |-> !dma_req_o);

  assert_word_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_rd_i && dma_req_o && remain_o >= CNT_W'(4)) |=> (remain_o == $past(remain_o) - CNT_W'(4)));

  assert_req_has_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (remain_o != '0));

  assert_done_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_done_o |=> !pkt_done_o);

  assert_irq_after_req_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !dma_req_o);

  assert_irq_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);

  assert_irq_blocks_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !$rose(dma_req_o));
endmodule

bind oep_dma_seq oep_dma_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dma_en_i   (dma_en_i),
  .word_rd_i  (word_rd_i),
  .irq_clr_i  (irq_clr_i),
  .dma_req_o  (dma_req_o),
  .irq_o      (irq_o),
  .pkt_done_o (pkt_done_o),
  .remain_o   (remain_o)
);

// File: tb/oep_dma_seq_tb_top.sv
`timescale 1ns/1ps
module oep_dma_seq_tb_top;
  localparam int NV = 11;
  // {mode, last, cnt, exp_reads, exp_irq, exp_done, exp_remain}
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 1'b0, 10'd64,   10'd16,  1'b0, 1'b1, 10'd0},  // R5
    {1'b0, 1'b0, 10'd6,    10'd2,   1'b0, 1'b1, 10'd0},  // R5 tail of 2
    {1'b0, 1'b0, 10'd3,    10'd1,   1'b0, 1'b1, 10'd0},  // R5 tail only
    {1'b0, 1'b0, 10'd0,    10'd0,   1'b0, 1'b1, 10'd0},  // R5 empty
    {1'b0, 1'b1, 10'd64,   10'd16,  1'b1, 1'b0, 10'd0},  // R6
    {1'b0, 1'b1, 10'd10,   10'd2,   1'b1, 1'b0, 10'd2},  // R6
    {1'b0, 1'b1, 10'd3,    10'd0,   1'b1, 1'b0, 10'd3},  // R6 no reads
    {1'b1, 1'b1, 10'd40,   10'd0,   1'b1, 1'b0, 10'd40}, // R7
    {1'b1, 1'b0, 10'd9,    10'd3,   1'b0, 1'b1, 10'd0},  // R10
    {1'b0, 1'b1, 10'd1023, 10'd255, 1'b1, 1'b0, 10'd3},  // R6 max
    {1'b0, 1'b0, 10'd1023, 10'd256, 1'b0, 1'b1, 10'd0}   // R5 max
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dma_en = 1'b0, mode = 1'b0, pkt_rdy = 1'b0, last = 1'b0;
  logic       word_rd = 1'b0, irq_clr = 1'b0;
  logic [9:0] cnt = '0;
  logic       dma_req, irq, done;
  logic [9:0] remain;

  int n_chk = 0, n_fail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  oep_dma_seq dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .dma_en_i   (dma_en),
    .dma_mode_i (mode),
    .pkt_rdy_i  (pkt_rdy),
    .pkt_cnt_i  (cnt),
    .pkt_last_i (last),
    .word_rd_i  (word_rd),
    .irq_clr_i  (irq_clr),
    .dma_req_o  (dma_req),
    .irq_o      (irq),
    .pkt_done_o (done),
    .remain_o   (remain)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      finish_run();
    end
  end

  task automatic release_pkt();
    @(negedge clk);
    pkt_rdy = 1'b0;
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 req", dma_req, 0);
    chk("R1 irq", irq, 0);
    chk("R1 done", done, 0);
    chk("R1 remain", remain, 0);
    rst_n = 1'b1;
    @(negedge clk);
    dma_en = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      int reads, dones, tail;
      logic got_irq;
      v = VEC[i];
      @(negedge clk);
      mode = v[33]; last = v[32]; cnt = v[31:22]; pkt_rdy = 1'b1;
      reads = 0; dones = 0; tail = 0; got_irq = 1'b0;
      for (int c = 0; c < 600; c++) begin
        @(negedge clk);
        word_rd = 1'b0;
        if (dma_req) begin word_rd = 1'b1; reads++; end
        if (done) dones++;
        if (irq) got_irq = 1'b1;
        if (dones > 0 || got_irq) tail++;
        if (tail > 4) break;
      end
      word_rd = 1'b0;
      // R9: pkt_rdy held high through tail window; extra reads would show here
      chk($sformatf("R5/R6/R7 reads vec%0d", i), reads, int'(v[21:12]));
      chk($sformatf("R6/R7/R8 irq vec%0d", i), got_irq, int'(v[11]));
      chk($sformatf("R5 done pulses vec%0d", i), dones, int'(v[10]));
      chk($sformatf("R3/R4 remain vec%0d", i), remain, int'(v[9:0]));
      release_pkt();
    end

    // R2: disabled DMA takes nothing up
    dma_en = 1'b0; mode = 1'b0; last = 1'b0; cnt = 10'd20; pkt_rdy = 1'b1;
    begin
      int seen;
      seen = 0;
      repeat (10) begin @(negedge clk); if (dma_req) seen++; end
      chk("R2 no request", seen, 0);
      chk("R2 remain not reloaded", remain, 0);
    end
    dma_en = 1'b1;
    @(negedge clk);
    chk("R3 request after enable", dma_req, 1);
    chk("R3 remain loaded", remain, 20);
    begin
      int guard;
      guard = 0;
      while (!done && guard < 50) begin
        word_rd = dma_req;
        @(negedge clk);
        guard++;
      end
      word_rd = 1'b0;
    end
    release_pkt();

    // R8: set interrupt blocks the next packet
    mode = 1'b1; last = 1'b1; cnt = 10'd40; pkt_rdy = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 irq set", irq, 1);
    pkt_rdy = 1'b0;
    @(negedge clk);
    mode = 1'b0; last = 1'b0; cnt = 10'd8; pkt_rdy = 1'b1;
    begin
      int seen;
      seen = 0;
      repeat (6) begin @(negedge clk); if (dma_req) seen++; end
      chk("R8 no request while irq", seen, 0);
      chk("R8 irq sticky", irq, 1);
      chk("R8 remain held", remain, 40);
    end
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R8 irq cleared", irq, 0);
    @(negedge clk);
    chk("R8 request after clear", dma_req, 1);
    chk("R8 remain after clear", remain, 8);
    word_rd = 1'b1;
    @(negedge clk);
    chk("R4 step of four", remain, 4);
    @(negedge clk);
    word_rd = 1'b0;
    chk("R5 drained", remain, 0);
    chk("R5 done pulse", done, 1);
    // R9: packet-ready still high, nothing restarts
    repeat (4) @(negedge clk);
    chk("R9 no restart", dma_req, 0);
    chk("R9 remain stays", remain, 0);
    release_pkt();

    finish_run();
  end
endmodule